// File: doc/BRIEF.md
# DMA Queue Channel Control State Machine

This block is the control and status slice of one queue in a multi-queue memory-copy DMA engine. Software talks to it through a small register port in a 256-byte per-channel window. It writes an enable bit and a pause bit in one control word and requests a self-clearing queue reset through a second word. It polls a 4-bit channel state and services a 13-bit interrupt status register. Status bits are cleared by writing ones. A mask register gates which bits drive the interrupt line.

On the datapath side the block sees a job-pending level, a job-done pulse and raw interrupt source pulses. It drives a run indication, the pause command and a one-cycle abort command. Job start is a valid/ready handshake: `start_valid` rises when the channel is ready to launch a job. It stays high while `start_ready` is low. The job is taken in the cycle both are high. The valid may drop without a transfer only when software disables or pauses the channel, or when a reset request is pending.

A reset request runs a buffer-clear phase of a fixed number of cycles. That phase wipes the pending interrupt status, and the channel then settles in IDLE.

Top module: `dmaq_chan_ctrl`

## Requirements
- R1: Out of reset the state reads IDLE (0), the run/abort/start outputs and `irq` are low, control word 0 reads 0, the status reads 0 and the mask reads 0x1FFF (all sources masked).
- R2: Register offsets are: control word 0 at 0x20 (bit 0 enable, bit 4 pause, independent), control word 1 at 0x24 (bit 0 reset request), state at 0x30 (bits 3:0), status at 0x40 and mask at 0x44 (bits 12:0). Reads of any other offset return 0.
- R3: The state encoding is IDLE=0, RUN=1, CPL=2, PAUSE=3, HALT=4, ABORT=5, WAIT=6, BUFFCLR=7. An enabled, unpaused IDLE channel with a job pending moves to WAIT.
- R4: `start_valid` is high exactly in WAIT. The job is taken, and the state becomes RUN, on the cycle after `start_valid` and `start_ready` are both high. WAIT falls back to IDLE if enable clears and to PAUSE if pause sets.
- R5: `job_done` in RUN moves the channel to CPL for one cycle and sets status bit 0. CPL then goes to PAUSE if enable and pause are both set, and to IDLE otherwise.
- R6: With pause set, no job is started: IDLE and WAIT go to PAUSE. A job already in RUN still completes. PAUSE returns to IDLE when pause or enable clears.
- R7: Clearing enable during RUN leaves RUN on the next clock edge. The channel enters ABORT for exactly one cycle with `abort_cmd` high, sets status bit 1, and then sits in HALT until a reset.
- R8: Writing 1 to bit 0 of control word 1 sets a reset request, and that bit reads back as 1. From IDLE, WAIT, PAUSE or HALT the request starts BUFFCLR, which clears the status and lasts CLR_CYCLES cycles. The channel then enters IDLE and the bit reads 0. In RUN, CPL and ABORT the request waits.
- R9: A high `int_src` bit sets its status bit. Writing ones to the status register clears those bits. A hardware set wins over a clear in the same cycle.
- R10: `irq` is the OR of the status bits that are not masked. A mask of all ones suppresses every source, and a mask of zero passes them all.
- R11: Writes to unmapped offsets, to the state register, or to control word 1 with bit 0 low change no register and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write offset in the channel window |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read offset in the channel window |
| rd_data | output | 32 | Read data for `rd_addr` (combinational) |
| job_pending | input | 1 | Datapath has a job queued |
| start_valid | output | 1 | Channel offers to start a job |
| start_ready | input | 1 | Datapath accepts the job start |
| job_done | input | 1 | Running job finished (pulse) |
| int_src | input | 13 | Raw interrupt source pulses |
| run_cmd | output | 1 | Channel is running a job |
| pause_cmd | output | 1 | Pause bit from control word 0 |
| abort_cmd | output | 1 | Abort the running job (one cycle) |
| chan_state | output | 4 | Current channel state |
| irq | output | 1 | Masked interrupt |

## Verification
A wrong transition shows on `chan_state` and on the read-back of offset 0x30 on the very next cycle. A wrong start handshake shows on `start_valid` or `run_cmd` one cycle after the offending input. A stuck or lost status bit shows up in the 0x40 read-back one cycle after the event. If that bit is unmasked, the same error also reaches `irq` in that cycle. A mishandled reset request shows as bit 0 of 0x24 staying high. It can also show as a BUFFCLR phase that ends one cycle early or late against the CLR_CYCLES count.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_RUN     = 4'd1,
    ST_CPL     = 4'd2,
    ST_PAUSE   = 4'd3,
    ST_HALT    = 4'd4,
    ST_ABORT   = 4'd5,
    ST_WAIT    = 4'd6,
    ST_BUFFCLR = 4'd7
  } chq_state_e;

  localparam logic [7:0] OFF_CTRL0 = 8'h20;
  localparam logic [7:0] OFF_CTRL1 = 8'h24;
  localparam logic [7:0] OFF_STATE = 8'h30;
  localparam logic [7:0] OFF_ISTS  = 8'h40;
  localparam logic [7:0] OFF_IMSK  = 8'h44;

  localparam int BIT_EN    = 0;
  localparam int BIT_PAUSE = 4;
  localparam int BIT_RST   = 0;

  localparam int EVT_DONE  = 0;
  localparam int EVT_ABORT = 1;
endpackage

// File: rtl/dmaq_fsm.sv
module dmaq_fsm
  import dmaq_pkg::*;
#(
  parameter int CLR_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       pause,
  input  logic       rst_pend,
  input  logic       job_pending,
  input  logic       start_ready,
  input  logic       job_done,
  output chq_state_e state,
  output logic       done_evt,
  output logic       abort_evt,
  output logic       clr_start,
  output logic       clr_finish
);
  localparam int CNT_W = $clog2(CLR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLR_CYCLES - 1);

  chq_state_e       state_d;
  logic [CNT_W-1:0] clr_cnt;

  assign clr_finish = (state == ST_BUFFCLR) && (clr_cnt == CNT_LAST);
  assign clr_start  = (state_d == ST_BUFFCLR) && (state != ST_BUFFCLR);
  assign done_evt   = (state == ST_RUN) && en && job_done;
  assign abort_evt  = (state == ST_RUN) && !en;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: begin
        if (rst_pend)                  state_d = ST_BUFFCLR;
        else if (en && pause)          state_d = ST_PAUSE;
        else if (en && job_pending)    state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rst_pend)                  state_d = ST_BUFFCLR;
        else if (!en)                  state_d = ST_IDLE;
        else if (pause)                state_d = ST_PAUSE;
        else if (start_ready)          state_d = ST_RUN;
      end
      ST_RUN: begin
        if (!en)                       state_d = ST_ABORT;
        else if (job_done)             state_d = ST_CPL;
      end
      ST_CPL:     state_d = (en && pause) ? ST_PAUSE : ST_IDLE;
      ST_PAUSE: begin
        if (rst_pend)                  state_d = ST_BUFFCLR;
        else if (!en || !pause)        state_d = ST_IDLE;
      end
      ST_ABORT:   state_d = ST_HALT;
      ST_HALT: begin
        if (rst_pend)                  state_d = ST_BUFFCLR;
      end
      ST_BUFFCLR: begin
        if (clr_finish)                state_d = ST_IDLE;
      end
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      clr_cnt <= '0;
    end else begin
      state   <= state_d;
      clr_cnt <= (state == ST_BUFFCLR && !clr_finish) ? clr_cnt + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/dmaq_regs.sv
module dmaq_regs
  import dmaq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int INT_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  chq_state_e        state,
  input  logic [INT_W-1:0]  int_src,
  input  logic              done_evt,
  input  logic              abort_evt,
  input  logic              clr_start,
  input  logic              clr_finish,
  output logic              en,
  output logic              pause,
  output logic              rst_pend,
  output logic [INT_W-1:0]  sts,
  output logic [INT_W-1:0]  mask
);
  logic wr_ctrl0, wr_ctrl1, wr_ists, wr_imsk;
  logic [INT_W-1:0] hw_set;

  assign wr_ctrl0 = wr_en && (wr_addr == ADDR_W'(OFF_CTRL0));
  assign wr_ctrl1 = wr_en && (wr_addr == ADDR_W'(OFF_CTRL1));
  assign wr_ists  = wr_en && (wr_addr == ADDR_W'(OFF_ISTS));
  assign wr_imsk  = wr_en && (wr_addr == ADDR_W'(OFF_IMSK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      pause    <= 1'b0;
      rst_pend <= 1'b0;
      mask     <= '1;
    end else begin
      if (wr_ctrl0) begin
        en    <= wr_data[BIT_EN];
        pause <= wr_data[BIT_PAUSE];
      end
      if (clr_finish)
        rst_pend <= 1'b0;
      else if (wr_ctrl1 && wr_data[BIT_RST])
        rst_pend <= 1'b1;
      if (wr_imsk)
        mask <= wr_data[INT_W-1:0];
    end
  end

  for (genvar gi = 0; gi < INT_W; gi++) begin : g_sts
    assign hw_set[gi] = int_src[gi]
                      | ((gi == EVT_DONE)  && done_evt)
                      | ((gi == EVT_ABORT) && abort_evt);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      sts[gi] <= 1'b0;
      else if (clr_start)              sts[gi] <= 1'b0;
      else if (hw_set[gi])             sts[gi] <= 1'b1;
      else if (wr_ists && wr_data[gi]) sts[gi] <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(OFF_CTRL0): begin
        rd_data[BIT_EN]    = en;
        rd_data[BIT_PAUSE] = pause;
      end
      ADDR_W'(OFF_CTRL1): rd_data[BIT_RST]  = rst_pend;
      ADDR_W'(OFF_STATE): rd_data[3:0]      = state;
      ADDR_W'(OFF_ISTS):  rd_data[INT_W-1:0] = sts;
      ADDR_W'(OFF_IMSK):  rd_data[INT_W-1:0] = mask;
      default:            rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dmaq_chan_ctrl.sv
module dmaq_chan_ctrl
  import dmaq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int INT_W      = 13,
  parameter int CLR_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              job_pending,
  output logic              start_valid,
  input  logic              start_ready,
  input  logic              job_done,
  input  logic [INT_W-1:0]  int_src,
  output logic              run_cmd,
  output logic              pause_cmd,
  output logic              abort_cmd,
  output logic [3:0]        chan_state,
  output logic              irq
);
  chq_state_e       state_q;
  logic             ctrl_en, ctrl_pause, rst_pend;
  logic             done_evt, abort_evt, clr_start, clr_finish;
  logic [INT_W-1:0] sts_q, mask_q;

  dmaq_fsm #(.CLR_CYCLES(CLR_CYCLES)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (ctrl_en),
    .pause       (ctrl_pause),
    .rst_pend    (rst_pend),
    .job_pending (job_pending),
    .start_ready (start_ready),
    .job_done    (job_done),
    .state       (state_q),
    .done_evt    (done_evt),
    .abort_evt   (abort_evt),
    .clr_start   (clr_start),
    .clr_finish  (clr_finish)
  );

  dmaq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_W(INT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .state      (state_q),
    .int_src    (int_src),
    .done_evt   (done_evt),
    .abort_evt  (abort_evt),
    .clr_start  (clr_start),
    .clr_finish (clr_finish),
    .en         (ctrl_en),
    .pause      (ctrl_pause),
    .rst_pend   (rst_pend),
    .sts        (sts_q),
    .mask       (mask_q)
  );

  assign start_valid = (state_q == ST_WAIT);
  assign run_cmd     = (state_q == ST_RUN);
  assign abort_cmd   = (state_q == ST_ABORT);
  assign pause_cmd   = ctrl_pause;
  assign chan_state  = state_q;
  assign irq         = |(sts_q & ~mask_q);
endmodule

// File: rtl/dmaq_chan_ctrl_chk.sv
module dmaq_chan_ctrl_chk
  import dmaq_pkg::*;
#(
  parameter int INT_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       chan_state,
  input logic             start_valid,
  input logic             start_ready,
  input logic             job_done,
  input logic             abort_cmd,
  input logic             irq,
  input logic             en,
  input logic             rst_pend,
  input logic [INT_W-1:0] sts,
  input logic [INT_W-1:0] mask
);
  AST_HANDSHAKE_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready && en) |=> (chan_state == ST_RUN) || (chan_state == ST_PAUSE) || (chan_state == ST_BUFFCLR)); // R4

  AST_CPL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_state == ST_CPL) |=> (chan_state == ST_IDLE) || (chan_state == ST_PAUSE)); // R5

  AST_DONE_SETS_STS: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_state == ST_RUN && en && job_done) |=> sts[EVT_DONE]); // R5

  AST_RUN_EXIT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_state == ST_RUN && !en) |=> (abort_cmd && sts[EVT_ABORT])); // R7

  AST_ABORT_TO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    abort_cmd |=> (chan_state == ST_HALT)); // R7

  AST_CLR_HAS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_state == ST_BUFFCLR) |-> rst_pend); // R8

  AST_MASK_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq); // R10

  AST_UNMASKED_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts & ~mask)) |-> irq); // R10
endmodule

bind dmaq_chan_ctrl dmaq_chan_ctrl_chk #(.INT_W(INT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chan_state  (chan_state),
  .start_valid (start_valid),
  .start_ready (start_ready),
  .job_done    (job_done),
  .abort_cmd   (abort_cmd),
  .irq         (irq),
  .en          (ctrl_en),
  .rst_pend    (rst_pend),
  .sts         (sts_q),
  .mask        (mask_q)
);

// File: tb/dmaq_chan_ctrl_tb.sv
module dmaq_chan_ctrl_tb;
  localparam int CLR = 4;
  localparam int IW  = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        job_pending = 1'b0, start_ready = 1'b0, job_done = 1'b0;
  logic [IW-1:0] int_src = '0;
  logic        start_valid, run_cmd, pause_cmd, abort_cmd, irq;
  logic [3:0]  chan_state;

  int vectors = 0;
  int misses  = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  dmaq_chan_ctrl #(.CLR_CYCLES(CLR)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .job_pending(job_pending),
    .start_valid(start_valid), .start_ready(start_ready), .job_done(job_done),
    .int_src(int_src), .run_cmd(run_cmd), .pause_cmd(pause_cmd),
    .abort_cmd(abort_cmd), .chan_state(chan_state), .irq(irq)
  );

  // reference model state
  logic [3:0]    m_st = 4'd0;
  logic          m_en = 0, m_pause = 0, m_rstp = 0;
  logic [IW-1:0] m_sts = '0, m_mask = '1;
  int            m_cnt = 0;

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    logic [31:0] r = '0;
    case (a)
      8'h20: begin r[0] = m_en; r[4] = m_pause; end
      8'h24: r[0] = m_rstp;
      8'h30: r[3:0] = m_st;
      8'h40: r[IW-1:0] = m_sts;
      8'h44: r[IW-1:0] = m_mask;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] next_st(input logic pend, input logic rdy, input logic dn);
    logic [3:0] n = m_st;
    case (m_st)
      4'd0: if (m_rstp) n = 7; else if (m_en && m_pause) n = 3; else if (m_en && pend) n = 6;
      4'd6: if (m_rstp) n = 7; else if (!m_en) n = 0; else if (m_pause) n = 3; else if (rdy) n = 1;
      4'd1: if (!m_en) n = 5; else if (dn) n = 2;
      4'd2: n = (m_en && m_pause) ? 4'd3 : 4'd0;
      4'd3: if (m_rstp) n = 7; else if (!m_en || !m_pause) n = 0;
      4'd5: n = 4;
      4'd4: if (m_rstp) n = 7;
      4'd7: if (m_cnt == CLR - 1) n = 0;
      default: n = 0;
    endcase
    return n;
  endfunction

  task automatic model_update(input logic w, input logic [7:0] a, input logic [31:0] d,
                              input logic pend, input logic rdy, input logic dn,
                              input logic [IW-1:0] src);
    logic [3:0] n = next_st(pend, rdy, dn);
    logic fin = (m_st == 4'd7) && (m_cnt == CLR - 1);
    logic cst = (n == 4'd7) && (m_st != 4'd7);
    logic [IW-1:0] setv = src;
    logic [IW-1:0] w1c = (w && a == 8'h40) ? d[IW-1:0] : '0;
    if (m_st == 4'd1 && m_en && dn) setv[0] = 1'b1;
    if (m_st == 4'd1 && !m_en) setv[1] = 1'b1;
    m_sts = cst ? '0 : ((m_sts & ~w1c) | setv);
    m_cnt = (m_st == 4'd7 && !fin) ? m_cnt + 1 : 0;
    m_rstp = fin ? 1'b0 : (m_rstp | (w && a == 8'h24 && d[0]));
    if (w && a == 8'h20) begin m_en = d[0]; m_pause = d[4]; end
    if (w && a == 8'h44) m_mask = d[IW-1:0];
    m_st = n;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    check({tag, " state"}, {28'd0, chan_state}, {28'd0, m_st});
    check("R4 start_valid", {31'd0, start_valid}, {31'd0, m_st == 4'd6});
    check("R7 abort_cmd", {31'd0, abort_cmd}, {31'd0, m_st == 4'd5});
    check("R5 run_cmd", {31'd0, run_cmd}, {31'd0, m_st == 4'd1});
    check("R10 irq", {31'd0, irq}, {31'd0, |(m_sts & ~m_mask)});
    check({tag, " read"}, rd_data, exp_rd(rd_addr));
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input string tag, input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic pend, input logic rdy, input logic dn,
                      input logic [IW-1:0] src, input logic [7:0] ra);
    wr_en = w; wr_addr = a; wr_data = d; job_pending = pend; start_ready = rdy;
    job_done = dn; int_src = src; rd_addr = ra;
    @(posedge clk);
    model_update(w, a, d, pend, rdy, dn, src);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag, input logic [7:0] ra);
    step(tag, 0, 8'h00, 32'd0, 0, 0, 0, '0, ra);
  endtask

  function automatic logic [7:0] pick_addr(input int k);
    case (k % 7)
      0: return 8'h20;
      1: return 8'h24;
      2: return 8'h30;
      3: return 8'h40;
      4: return 8'h44;
      5: return 8'h2C;
      default: return 8'h00;
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5EED_0143));
    repeat (3) @(negedge clk);
    rd_addr = 8'h44;
    #1;
    check("R1 mask at reset", rd_data, 32'h0000_1FFF);
    check("R1 state at reset", {28'd0, chan_state}, 32'd0);
    check("R1 irq at reset", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    idle("R1", 8'h20);
    idle("R1", 8'h40);

    // enable, job start handshake, completion
    step("R2", 1, 8'h20, 32'h1, 0, 0, 0, '0, 8'h20);
    step("R3", 0, 8'h00, 0, 1, 0, 0, '0, 8'h30);
    check("R3 WAIT code", {28'd0, chan_state}, 32'd6);
    step("R4", 0, 8'h00, 0, 1, 0, 0, '0, 8'h30);
    step("R4", 0, 8'h00, 0, 1, 1, 0, '0, 8'h30);
    check("R4 RUN code", {28'd0, chan_state}, 32'd1);
    step("R5", 0, 8'h00, 0, 0, 0, 1, '0, 8'h40);
    check("R5 CPL code", {28'd0, chan_state}, 32'd2);
    idle("R5", 8'h40);
    check("R5 done bit", rd_data, 32'h1);
    // unmask and clear
    step("R10", 1, 8'h44, 32'h0, 0, 0, 0, '0, 8'h44);
    check("R10 irq unmasked", {31'd0, irq}, 32'd1);
    step("R9", 1, 8'h40, 32'h1, 0, 0, 0, 13'h0004, 8'h40);
    check("R9 clear and set", rd_data, 32'h4);
    step("R9", 1, 8'h40, 32'h4, 0, 0, 0, 13'h0004, 8'h40);
    check("R9 set beats clear", rd_data, 32'h4);
    step("R9", 1, 8'h40, 32'hFFFF, 0, 0, 0, '0, 8'h40);
    // pause with job in flight
    step("R6", 0, 8'h00, 0, 1, 1, 0, '0, 8'h30);
    step("R6", 0, 8'h00, 0, 1, 1, 0, '0, 8'h30);
    step("R6", 1, 8'h20, 32'h11, 1, 1, 0, '0, 8'h30);
    step("R6", 0, 8'h00, 0, 1, 1, 1, '0, 8'h30);
    idle("R6", 8'h30);
    check("R6 paused code", {28'd0, chan_state}, 32'd3);
    idle("R6", 8'h30);
    step("R6", 1, 8'h20, 32'h1, 0, 0, 0, '0, 8'h30);
    // unmapped writes and ignored reset bit
    step("R11", 1, 8'h2C, 32'hFFFF_FFFF, 0, 0, 0, '0, 8'h20);
    step("R11", 1, 8'h30, 32'hFFFF_FFFF, 0, 0, 0, '0, 8'h30);
    step("R11", 1, 8'h24, 32'hFFFF_FFFE, 0, 0, 0, '0, 8'h24);
    check("R11 ctrl1 unchanged", rd_data, 32'h0);
    // disable while running
    step("R7", 0, 8'h00, 0, 1, 1, 0, '0, 8'h30);
    step("R7", 0, 8'h00, 0, 1, 1, 0, '0, 8'h30);
    step("R7", 1, 8'h20, 32'h0, 0, 0, 0, '0, 8'h30);
    idle("R7", 8'h30);
    check("R7 abort pulse", {31'd0, abort_cmd}, 32'd1);
    idle("R7", 8'h40);
    check("R7 halt", {28'd0, chan_state}, 32'd4);
    // reset from HALT
    step("R8", 1, 8'h24, 32'h1, 0, 0, 0, '0, 8'h24);
    check("R8 pending bit", rd_data, 32'h1);
    for (int i = 0; i < CLR + 2; i++) idle("R8", (i % 2 == 0) ? 8'h24 : 8'h40);
    check("R8 back to idle", {28'd0, chan_state}, 32'd0);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      logic w = ($urandom % 6) == 0;
      logic [7:0] a = pick_addr($urandom);
      logic [31:0] d = $urandom;
      logic [IW-1:0] src = '0;
      if (a == 8'h20) begin d[0] = ($urandom % 4) != 0; d[4] = ($urandom % 4) == 0; end
      if (a == 8'h24) d[0] = ($urandom % 3) == 0;
      if (($urandom % 12) == 0) src[$urandom % IW] = 1'b1;
      step("R3", w, a, d, ($urandom % 2) == 0, ($urandom % 3) != 0,
           ($urandom % 3) == 0, src, pick_addr($urandom));
    end

    done_flag = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule